// File: doc/BRIEF.md
# Lookup-Table Ternary Match Memory

This block is a ternary content-addressable memory. It holds `NUM_ENTRIES` entries of `KEY_W` bits each, and every stored bit can be 0, 1 or don't-care. Each entry is not kept as a value and a mask. The entry is split into 4-bit slices, and each slice becomes a 16-bit bit table. The matching 4 bits of the search key index that table, and the table bit answers whether that key nibble matches the slice. The bit tables are filled serially. One write streams a table bit into every slice of the chosen entry on each of 16 consecutive cycles, starting at table address 15 and ending at address 0.

A search applies the key to all entries in the same cycle. The slice answers of each entry are ANDed into one hit line per entry, together with the entry's valid flag. A registered two-level tree of priority encoders then reduces the hit lines to the lowest matching index. The search port is fully pipelined: it accepts one key per cycle and returns a result three cycles later. The write port takes an entry index, a value, a mask and a start pulse, and holds `busy` high while the tables are loading.

Top module: `tcam_lut`

## Requirements
- R1: After reset, `busy_o` and `res_valid_o` are 0 and every entry is invalid.
- R2: A mask bit of 1 marks the stored bit as don't-care. A valid entry matches a key when every key bit whose mask bit is 0 equals the stored value bit.
- R3: A start request accepted while idle raises `busy_o` for exactly 16 cycles. Keys sampled once `busy_o` is low again see the new contents.
- R4: A start request made while `busy_o` is high is ignored. It does not extend the load, and the index it names stays unchanged.
- R5: The entry under rewrite gives no hit for any key sampled after the edge that accepted the write, until its load completes.
- R6: When several valid entries match, the reported address is the lowest matching index, including when the matches lie in different encoder groups.
- R7: A search with no matching valid entry returns `res_hit_o`=0 and `res_addr_o`=0, and `res_valid_o` still pulses for that search.
- R8: A key sampled with `search_valid_i`=1 at rising edge n produces `res_valid_o`=1 after edge n+2. A new key can be taken every cycle, and `res_hit_o` is never 1 without `res_valid_o`.
- R9: An entry that has never been written never hits, whatever the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Request to load one entry |
| wr_idx_i | input | IDX_W | Index of the entry to load |
| wr_value_i | input | KEY_W | Stored value bits |
| wr_mask_i | input | KEY_W | Don't-care mask (1 = don't care) |
| busy_o | output | 1 | Load in progress |
| search_valid_i | input | 1 | Key present this cycle |
| search_key_i | input | KEY_W | Search key |
| res_valid_o | output | 1 | Search result valid |
| res_hit_o | output | 1 | At least one entry matched |
| res_addr_o | output | IDX_W | Lowest matching index, 0 on miss |

## Verification
On every cycle the assertions check the following: the length of the busy window, that busy rises only after a request, the fixed three-cycle result latency, that a miss reports a zero address, and that a hit never appears without a valid result. Some behaviour can be shown only by the bench's scenarios. This covers the ternary match semantics of the loaded bit tables and lowest-index priority across and within encoder groups. It also covers dropping a start request made during a load, and hiding an entry while it is rewritten. For these the bench compares every result against a reference search over its own copy of the entry values, masks and valid flags.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned SLICE_W   = 4;
  localparam int unsigned TBL_DEPTH = 1 << SLICE_W;

  // Table bit for read address addr: set when addr agrees with val on all unmasked bits
  function automatic logic table_bit(input logic [SLICE_W-1:0] val,
                                     input logic [SLICE_W-1:0] msk,
                                     input logic [SLICE_W-1:0] addr);
    return ((addr ^ val) & ~msk) == '0;
  endfunction
endpackage

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tcam_loader.sv
module tcam_loader
  import tcam_pkg::*;
#(
  parameter int unsigned KEY_W = 32,
  parameter int unsigned IDX_W = 11,
  localparam int unsigned NUM_SLICES = KEY_W / SLICE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_start_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [KEY_W-1:0]      wr_value_i,
  input  logic [KEY_W-1:0]      wr_mask_i,
  output logic                  busy_o,
  output logic                  load_o,
  output logic [IDX_W-1:0]      load_idx_o,
  output logic [NUM_SLICES-1:0] load_bits_o,
  output logic                  clr_o,
  output logic [IDX_W-1:0]      clr_idx_o,
  output logic                  done_o
);
  logic               busy_q;
  logic [SLICE_W-1:0] cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [KEY_W-1:0]   val_q, msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      val_q  <= '0;
      msk_q  <= '0;
    end else if (!busy_q) begin
      if (wr_start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= SLICE_W'(TBL_DEPTH - 1);
        idx_q  <= wr_idx_i;
        val_q  <= wr_value_i;
        msk_q  <= wr_mask_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // cnt_q walks the table address from top to bottom
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_bits
    assign load_bits_o[s] = table_bit(val_q[s*SLICE_W +: SLICE_W],
                                      msk_q[s*SLICE_W +: SLICE_W], cnt_q);
  end

  assign busy_o     = busy_q;
  assign load_o     = busy_q;
  assign load_idx_o = idx_q;
  assign clr_o      = wr_start_i & ~busy_q;
  assign clr_idx_o  = wr_idx_i;
  assign done_o     = busy_q & (cnt_q == '0);
endmodule

// File: rtl/tcam_entry.sv
module tcam_entry
  import tcam_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 8,
  localparam int unsigned KEY_W = NUM_SLICES * SLICE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NUM_SLICES-1:0] load_bits_i,
  input  logic                  clr_i,
  input  logic                  set_i,
  input  logic [KEY_W-1:0]      key_i,
  output logic                  match_o
);
  logic [NUM_SLICES-1:0][TBL_DEPTH-1:0] tbl_q;
  logic [NUM_SLICES-1:0]                slice_hit;
  logic                                 valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= 1'b0;
    else if (clr_i) valid_q <= 1'b0;
    else if (set_i) valid_q <= 1'b1;
  end

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    always_ff @(posedge clk_i) begin
      if (load_i) tbl_q[s] <= {tbl_q[s][TBL_DEPTH-2:0], load_bits_i[s]};
    end
    assign slice_hit[s] = tbl_q[s][key_i[s*SLICE_W +: SLICE_W]];
  end

  assign match_o = valid_q & (&slice_hit);
endmodule

// File: rtl/tcam_lut.sv
module tcam_lut
  import tcam_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 2048,
  parameter int unsigned KEY_W       = 32,
  parameter int unsigned GROUP_SIZE  = 64,
  parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_start_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [KEY_W-1:0] wr_value_i,
  input  logic [KEY_W-1:0] wr_mask_i,
  output logic             busy_o,
  input  logic             search_valid_i,
  input  logic [KEY_W-1:0] search_key_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic [IDX_W-1:0] res_addr_o
);
  localparam int unsigned NUM_SLICES = KEY_W / SLICE_W;
  localparam int unsigned NUM_GROUPS = NUM_ENTRIES / GROUP_SIZE;
  localparam int unsigned GIDX_W     = $clog2(GROUP_SIZE);
  localparam int unsigned GSEL_W     = $clog2(NUM_GROUPS);

  logic                  load;
  logic [IDX_W-1:0]      load_idx;
  logic [NUM_SLICES-1:0] load_bits;
  logic                  clr;
  logic [IDX_W-1:0]      clr_idx;
  logic                  done;

  tcam_loader #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_loader (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_start_i  (wr_start_i),
    .wr_idx_i    (wr_idx_i),
    .wr_value_i  (wr_value_i),
    .wr_mask_i   (wr_mask_i),
    .busy_o      (busy_o),
    .load_o      (load),
    .load_idx_o  (load_idx),
    .load_bits_o (load_bits),
    .clr_o       (clr),
    .clr_idx_o   (clr_idx),
    .done_o      (done)
  );

  // Stage 0: match all entries against the incoming key
  logic [NUM_ENTRIES-1:0] match_d;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    tcam_entry #(.NUM_SLICES(NUM_SLICES)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load && (load_idx == IDX_W'(i))),
      .load_bits_i (load_bits),
      .clr_i       (clr && (clr_idx == IDX_W'(i))),
      .set_i       (done && (load_idx == IDX_W'(i))),
      .key_i       (search_key_i),
      .match_o     (match_d[i])
    );
  end

  logic [NUM_ENTRIES-1:0] hit_q;
  logic                   v1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= '0;
      v1_q  <= 1'b0;
    end else begin
      hit_q <= match_d;
      v1_q  <= search_valid_i;
    end
  end

  // Stage 1: per-group lowest-index encode
  logic [NUM_GROUPS-1:0]  g_found_d, g_found_q;
  logic [GIDX_W-1:0]      g_idx_d [NUM_GROUPS];
  logic [GIDX_W-1:0]      g_idx_q [NUM_GROUPS];
  logic                   v2_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    tcam_prio_enc #(.W(GROUP_SIZE), .IW(GIDX_W)) u_enc (
      .req_i   (hit_q[g*GROUP_SIZE +: GROUP_SIZE]),
      .found_o (g_found_d[g]),
      .idx_o   (g_idx_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) g_idx_q[g] <= '0;
      else         g_idx_q[g] <= g_idx_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_found_q <= '0;
      v2_q      <= 1'b0;
    end else begin
      g_found_q <= g_found_d;
      v2_q      <= v1_q;
    end
  end

  // Stage 2: pick lowest group with a hit
  logic              f_found;
  logic [GSEL_W-1:0] f_sel;

  tcam_prio_enc #(.W(NUM_GROUPS), .IW(GSEL_W)) u_top_enc (
    .req_i   (g_found_q),
    .found_o (f_found),
    .idx_o   (f_sel)
  );

  logic             res_valid_q, res_hit_q;
  logic [IDX_W-1:0] res_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_addr_q  <= '0;
    end else begin
      res_valid_q <= v2_q;
      res_hit_q   <= v2_q & f_found;
      res_addr_q  <= (v2_q & f_found) ? {f_sel, g_idx_q[f_sel]} : '0;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_hit_o   = res_hit_q;
  assign res_addr_o  = res_addr_q;
endmodule

// File: rtl/tcam_lut_checker.sv
module tcam_lut_checker #(
  parameter int unsigned IDX_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_start_i,
  input logic             busy_o,
  input logic             search_valid_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic [IDX_W-1:0] res_addr_o
);
  logic [4:0] left_q;
  logic [2:0] sv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sv_q   <= '0;
    end else begin
      sv_q <= {sv_q[1:0], search_valid_i};
      if (wr_start_i && !busy_o) left_q <= 5'd16;
      else if (left_q != '0)     left_q <= left_q - 1'b1;
    end
  end

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (left_q != '0));

  p_busy_from_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_start_i));

  p_miss_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_addr_o == '0));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == sv_q[2]);

  p_hit_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_valid_o);
endmodule

bind tcam_lut tcam_lut_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_start_i     (wr_start_i),
  .busy_o         (busy_o),
  .search_valid_i (search_valid_i),
  .res_valid_o    (res_valid_o),
  .res_hit_o      (res_hit_o),
  .res_addr_o     (res_addr_o)
);

// File: tb/tb_tcam_lut.sv
`timescale 1ns/1ps
module tb_tcam_lut;
  localparam int N   = 256;
  localparam int GS  = 16;
  localparam int IW  = 8;
  localparam int KW  = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_start_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [KW-1:0] wr_value_i = '0;
  logic [KW-1:0] wr_mask_i = '0;
  logic          busy_o;
  logic          search_valid_i = 1'b0;
  logic [KW-1:0] search_key_i = '0;
  logic          res_valid_o, res_hit_o;
  logic [IW-1:0] res_addr_o;

  always #2.5 clk_i = ~clk_i;

  tcam_lut #(.NUM_ENTRIES(N), .KEY_W(KW), .GROUP_SIZE(GS), .IDX_W(IW)) dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [KW-1:0] val_m [N];
  logic [KW-1:0] msk_m [N];
  bit            vld_m [N];

  logic          p_v    [3];
  logic          p_hit  [3];
  logic [IW-1:0] p_addr [3];
  string         p_tag  [3];
  string         cur_tag = "";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void ref_search(input logic [KW-1:0] k, output logic hit,
                                     output logic [IW-1:0] addr);
    hit = 0; addr = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vld_m[i] && (((k ^ val_m[i]) & ~msk_m[i]) == '0)) begin
        hit = 1; addr = IW'(i);
      end
  endfunction

  // expected result pipeline, advanced with the design
  initial begin
    for (int i = 0; i < 3; i++) begin p_v[i] = 0; p_hit[i] = 0; p_addr[i] = '0; p_tag[i] = ""; end
    forever begin
      @(posedge clk_i);
      for (int i = 2; i > 0; i--) begin
        p_v[i] = p_v[i-1]; p_hit[i] = p_hit[i-1]; p_addr[i] = p_addr[i-1]; p_tag[i] = p_tag[i-1];
      end
      p_v[0] = rst_ni && search_valid_i;
      ref_search(search_key_i, p_hit[0], p_addr[0]);
      p_tag[0] = cur_tag;
    end
  end

  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && (p_v[2] || res_valid_o)) begin
        chk(res_valid_o == p_v[2], "R8", "result valid", res_valid_o, p_v[2]);
        if (p_v[2]) begin
          chk(res_hit_o == p_hit[2], p_hit[2] ? p_tag[2] : {p_tag[2], " R7"}, "hit",
              res_hit_o, p_hit[2]);
          chk(res_addr_o == p_addr[2], p_hit[2] ? {p_tag[2], " R6"} : {p_tag[2], " R7"},
              "addr", res_addr_o, p_addr[2]);
        end
      end
    end
  end

  task automatic drive_key(input logic [KW-1:0] k, input string tag);
    @(negedge clk_i);
    search_key_i = k; search_valid_i = 1'b1; cur_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk_i);
    search_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  // intrude >= 0: issue a second request for that index during the load
  task automatic do_write(input int idx, input logic [KW-1:0] v, input logic [KW-1:0] m,
                          input int intrude, input logic [KW-1:0] iv, input bit hold);
    int cnt;
    @(negedge clk_i);
    wr_start_i = 1'b1; wr_idx_i = IW'(idx); wr_value_i = v; wr_mask_i = m;
    vld_m[idx] = 0;
    @(negedge clk_i);
    wr_start_i = 1'b0;
    cnt = 0;
    while (busy_o && cnt < 40) begin
      cnt++;
      if (intrude >= 0 && cnt == 3) begin
        wr_start_i = 1'b1; wr_idx_i = IW'(intrude); wr_value_i = iv; wr_mask_i = '0;
      end else begin
        wr_start_i = 1'b0;
      end
      if (hold) drive_key(val_m[idx], "R5");
      else      @(negedge clk_i);
    end
    wr_start_i = 1'b0;
    if (hold) search_valid_i = 1'b0;
    chk(cnt == 16, intrude >= 0 ? "R4" : "R3", "busy cycles", cnt, 16);
    val_m[idx] = v; msk_m[idx] = m; vld_m[idx] = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin val_m[i] = '0; msk_m[i] = '0; vld_m[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(res_valid_o == 1'b0, "R1", "valid after reset", res_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // empty memory: every key misses
    drive_key(32'h0000_0000, "R1 R9");
    drive_key(32'hFFFF_FFFF, "R1 R9");
    drive_key(32'h1234_5678, "R1 R9");
    flush();

    // exact entry vs one-bit difference
    do_write(10, 32'hDEAD_BEEF, 32'h0, -1, '0, 0);
    drive_key(32'hDEAD_BEEF, "R2");
    drive_key(32'hDEAD_BEEE, "R2");
    drive_key(32'h5EAD_BEEF, "R2");
    flush();

    // masked nibble: low byte don't care
    do_write(3, 32'hCAFE_0000, 32'h0000_00FF, -1, '0, 0);
    drive_key(32'hCAFE_00A5, "R2");
    drive_key(32'hCAFE_01A5, "R2");
    flush();

    // priority within a group and across groups
    do_write(41, 32'hAAAA_5555, 32'h0, -1, '0, 0);
    do_write(40, 32'hAAAA_5550, 32'h0000_000F, -1, '0, 0);
    drive_key(32'hAAAA_5555, "R6");
    do_write(200, 32'h0F0F_0F0F, 32'h0, -1, '0, 0);
    do_write(5, 32'h0F0F_0000, 32'h0000_FFFF, -1, '0, 0);
    drive_key(32'h0F0F_0F0F, "R6");
    drive_key(32'h1F0F_0F0F, "R6");
    flush();

    // request during a load is dropped
    do_write(60, 32'h1111_2222, 32'h0, 61, 32'h7777_8888, 0);
    drive_key(32'h7777_8888, "R4 R9");
    drive_key(32'h1111_2222, "R4");
    flush();

    // rewrite hides the entry until done
    do_write(10, 32'h0BAD_F00D, 32'h0, -1, '0, 1);
    flush();
    drive_key(32'hDEAD_BEEF, "R5");
    drive_key(32'h0BAD_F00D, "R5 R3");
    flush();

    // all-don't-care entry at a high index catches everything
    do_write(250, 32'h0, 32'hFFFF_FFFF, -1, '0, 0);
    drive_key(32'h9999_9999, "R2 R6");
    flush();

    // random population and back-to-back search stream
    for (int w = 0; w < 40; w++) begin
      int idx = int'($urandom_range(N - 1, 0));
      do_write(idx, $urandom, $urandom & $urandom & $urandom, -1, '0, 0);
    end
    for (int s = 0; s < 400; s++) begin
      int j = int'($urandom_range(N - 1, 0));
      if ($urandom_range(1, 0) == 0) drive_key(val_m[j] ^ ($urandom & msk_m[j]), "R2 R6 R8");
      else                           drive_key($urandom, "R2 R6 R8");
    end
    flush();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule